// File: doc/BRIEF.md
# Multi-Source Initial Reset Controller

This block produces the system initial reset for a small 4-bit microcontroller core that runs from a slow oscillator clock of about 32.768 kHz. The reset can come from three sources. The first is a watchdog on the oscillator itself, which is clocked from a separate slow reference clock. The second is a reset pin driven high from outside. The third is a key chord, in which a chosen group of the four input port lines is held high together. Each external source passes through a two-flop synchronizer. It then passes through a duration filter, so that a short pulse is treated as noise and ignored.

The reset asserts asynchronously as soon as any source qualifies. It releases on the oscillator edge that follows the clearing of the last source. On that release a one-cycle start strobe tells the core to begin fetching. While reset is active, the block drives the values the core loads into its registers: program counter step, program counter page, new page pointer, and clear strobes for the interrupt and decimal flags.

Top module: `initial_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises until the oscillator watchdog has seen one complete handshake round trip, `sys_rst` stays high.
- R2: The pin source asserts `sys_rst` only when `pin_rst` has been sampled high on PIN_LEN consecutive oscillator edges. A shorter pulse has no effect. `sys_rst` rises right after the (PIN_LEN+2)-th rising edge counted from the first edge that samples the pin high.
- R3: The chord source depends on the `KEY_SEL` encoding: 0 is off, 1 needs lines 0 and 1, 2 needs lines 0 to 2, and 3 needs all four lines (bit i of `key_in` is line i). Lines that are not selected have no effect.
- R4: The chord source asserts `sys_rst` after all selected lines have been sampled high together on KEY_LEN consecutive edges. If any selected line drops for even one edge, the count restarts.
- R5: With `KEY_SEL` = 0, no pattern on `key_in` asserts reset, whatever its duration.
- R6: If the oscillator stops, `sys_rst` asserts without any oscillator edge, within about OSC_TIMEOUT+3 reference periods. After the oscillator restarts, `sys_rst` releases within a few reference periods.
- R7: `sys_rst` falls on the first oscillator edge after every source has cleared. For the pin source, this is the fourth edge counted from the first edge that samples the pin low.
- R8: `core_start` is high for exactly one oscillator cycle, and only in the cycle that follows the fall of `sys_rst`.
- R9: While `sys_rst` is high, `init_pc_step` = 8'h00, `init_pc_page` = 4'h1, `init_np_page` = 4'h1, and `clr_iflag` and `clr_dflag` are high. While `sys_rst` is low, all of these outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being supervised; it also clocks the filters |
| clk_ref | input | 1 | Independent slow reference clock for the oscillator watchdog |
| rst_n | input | 1 | Power-on reset, active low, sampled synchronously in each domain |
| pin_rst | input | 1 | External reset request, active high, asynchronous |
| key_in | input | 4 | Input port lines used for the chord reset, asynchronous |
| sys_rst | output | 1 | Combined initial reset, active high |
| core_start | output | 1 | One-cycle strobe when the core may begin running |
| init_pc_step | output | 8 | Program counter step value to load during reset |
| init_pc_page | output | 4 | Program counter page value to load during reset |
| init_np_page | output | 4 | New page pointer value to load during reset |
| clr_iflag | output | 1 | Clear strobe for the interrupt flag |
| clr_dflag | output | 1 | Clear strobe for the decimal flag |

## Verification
Each filtered source has a fixed latency. Two synchronizer edges plus the filter length give PIN_LEN+2 or KEY_LEN+2 edges from the first edge that samples the input high. Release takes four edges after the input is sampled low, and `core_start` rises on that same fourth edge. The bench drives inputs just after a rising edge and steps whole edges. It then checks the cycle before the due edge (expecting no change) and the due edge itself (expecting the change). The oscillator-stop case has no edges to count. For that case the bench waits a fixed time well beyond the timeout in reference periods, and then waits a fixed bound for the release after restart.

// File: rtl/rst_pkg.sv
// Shared types and constants for the initial reset controller.
// Assumes the core uses an 8-bit program counter step and 4-bit pages.
package rst_pkg;

    localparam int STEP_W = 8;
    localparam int PAGE_W = 4;

    localparam logic [STEP_W-1:0] INIT_STEP = 8'h00;
    localparam logic [PAGE_W-1:0] INIT_PAGE = 4'h1;
    localparam logic [PAGE_W-1:0] INIT_NPP  = 4'h1;

    // Chord selection: which input lines must be high together.
    typedef enum logic [1:0] {
        KEYSEL_OFF   = 2'd0,
        KEYSEL_TWO   = 2'd1,
        KEYSEL_THREE = 2'd2,
        KEYSEL_FOUR  = 2'd3
    } keysel_e;

    // Map a chord selection onto a mask of required lines.
    function automatic logic [3:0] key_mask(keysel_e sel);
        case (sel)
            KEYSEL_TWO:   return 4'b0011;
            KEYSEL_THREE: return 4'b0111;
            KEYSEL_FOUR:  return 4'b1111;
            default:      return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/rst_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that is slow with respect to clk.
module rst_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture and re-time the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/rst_dur_filter.sv
// Duration filter: the output is high once the input has been high on
// LEN consecutive clock edges. Any low sample restarts the count.
// Assumes din is already synchronous to clk and LEN >= 1.
module rst_dur_filter #(
    parameter int LEN = 164
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic qualified
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LEN);

    logic [CW-1:0] run_cnt;

    // Count consecutive high samples and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !din) begin
            run_cnt <= '0;
        end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign qualified = (run_cnt == LIMIT);
endmodule

// File: rtl/rst_osc_watch.sv
// Oscillator watchdog. A request toggle runs from the reference domain
// into the oscillator domain and back. If no round trip completes within
// TIMEOUT reference periods, the oscillator is declared stopped. Before the
// first completed round trip after reset, it is also declared stopped.
// Assumes clk_ref is independent of clk_osc and TIMEOUT >= 4.
module rst_osc_watch #(
    parameter int TIMEOUT = 8
) (
    input  logic clk_osc,
    input  logic clk_ref,
    input  logic rst_n,
    output logic osc_dead
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic          req;
    logic [1:0]    echo;
    logic [1:0]    ack_s;
    logic [CW-1:0] idle_cnt;
    logic          seen;

    // Oscillator side: echo the request back through two flops.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            echo <= '0;
        end else begin
            echo <= {echo[0], req};
        end
    end

    // Reference side: resynchronize the echo.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            ack_s <= '0;
        end else begin
            ack_s <= {ack_s[0], echo[1]};
        end
    end

    // Reference side: toggle on a completed round trip, else age the counter.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            req      <= 1'b0;
            idle_cnt <= '0;
            seen     <= 1'b0;
        end else if (ack_s[1] == req) begin
            req      <= ~req;
            idle_cnt <= '0;
            if (req) begin
                seen <= 1'b1;
            end
        end else if (idle_cnt != LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign osc_dead = !seen || (idle_cnt == LIMIT);
endmodule

// File: rtl/initial_reset_ctrl.sv
// Top of the initial reset controller. It merges the oscillator watchdog,
// the filtered reset pin and the filtered key chord into one reset that
// sets asynchronously and releases on clk_osc. It also provides the core's
// start strobe and the register load values.
// Assumes clk_osc is about 32.768 kHz and rst_n is held low over several
// edges of both clocks.
module initial_reset_ctrl #(
    parameter int               PIN_LEN     = 164,
    parameter int               KEY_LEN     = 131072,
    parameter int               OSC_TIMEOUT = 8,
    parameter rst_pkg::keysel_e KEY_SEL     = rst_pkg::KEYSEL_FOUR
) (
    input  logic                       clk_osc,
    input  logic                       clk_ref,
    input  logic                       rst_n,
    input  logic                       pin_rst,
    input  logic [3:0]                 key_in,
    output logic                       sys_rst,
    output logic                       core_start,
    output logic [rst_pkg::STEP_W-1:0] init_pc_step,
    output logic [rst_pkg::PAGE_W-1:0] init_pc_page,
    output logic [rst_pkg::PAGE_W-1:0] init_np_page,
    output logic                       clr_iflag,
    output logic                       clr_dflag
);
    localparam logic [3:0] KEY_MASK = rst_pkg::key_mask(KEY_SEL);

    logic       pin_s;
    logic [3:0] key_s;
    logic       pin_ok;
    logic       key_ok;
    logic       key_chord;
    logic       osc_dead;
    logic       rst_req;
    logic       hold;
    logic       hold_d;

    rst_sync2 #(.W(5)) u_sync (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .din   ({pin_rst, key_in}),
        .dout  ({pin_s, key_s})
    );

    rst_dur_filter #(.LEN(PIN_LEN)) u_pin_flt (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .din       (pin_s),
        .qualified (pin_ok)
    );

    // Chord decode: each line is either required and high, or not required.
    generate
        if (KEY_MASK == 4'b0000) begin : g_chord_off
            assign key_chord = 1'b0;
        end else begin : g_chord_on
            logic [3:0] line_ok;
            for (genvar i = 0; i < 4; i++) begin : g_line
                assign line_ok[i] = key_s[i] | ~KEY_MASK[i];
            end
            assign key_chord = &line_ok;
        end
    endgenerate

    rst_dur_filter #(.LEN(KEY_LEN)) u_key_flt (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .din       (key_chord),
        .qualified (key_ok)
    );

    rst_osc_watch #(.TIMEOUT(OSC_TIMEOUT)) u_osc (
        .clk_osc  (clk_osc),
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .osc_dead (osc_dead)
    );

    assign rst_req = osc_dead | pin_ok | key_ok;

    // Set the reset immediately on a request; release it on the next edge.
    always_ff @(posedge clk_osc or posedge rst_req) begin
        if (rst_req) begin
            hold <= 1'b1;
        end else begin
            hold <= 1'b0;
        end
    end

    // Keep the previous reset level to find the release edge.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            hold_d <= 1'b1;
        end else begin
            hold_d <= hold;
        end
    end

    assign sys_rst      = hold;
    assign core_start   = hold_d & ~hold;
    assign init_pc_step = hold ? rst_pkg::INIT_STEP : '0;
    assign init_pc_page = hold ? rst_pkg::INIT_PAGE : '0;
    assign init_np_page = hold ? rst_pkg::INIT_NPP  : '0;
    assign clr_iflag    = hold;
    assign clr_dflag    = hold;
endmodule

// File: rtl/initial_reset_ctrl_sva.sv
// Checker for the initial reset controller. It is bound to every instance.
// It counts raw input run lengths by itself and relates them to the outputs.
module initial_reset_ctrl_sva #(
    parameter int               PIN_LEN = 164,
    parameter int               KEY_LEN = 131072,
    parameter rst_pkg::keysel_e KEY_SEL = rst_pkg::KEYSEL_FOUR
) (
    input logic                       clk_osc,
    input logic                       rst_n,
    input logic                       pin_rst,
    input logic [3:0]                 key_in,
    input logic                       sys_rst,
    input logic                       core_start,
    input logic [rst_pkg::STEP_W-1:0] init_pc_step,
    input logic [rst_pkg::PAGE_W-1:0] init_pc_page,
    input logic [rst_pkg::PAGE_W-1:0] init_np_page,
    input logic                       clr_iflag,
    input logic                       clr_dflag
);
    localparam logic [3:0] MASK = rst_pkg::key_mask(KEY_SEL);
    localparam int PW = $clog2(PIN_LEN + 3);
    localparam int KW = $clog2(KEY_LEN + 3);
    localparam logic [PW-1:0] PIN_DUE = PW'(PIN_LEN + 2);
    localparam logic [KW-1:0] KEY_DUE = KW'(KEY_LEN + 2);

    logic [PW-1:0] pin_run;
    logic [KW-1:0] key_run;

    // Count consecutive raw high samples of the pin and of the chord.
    always_ff @(posedge clk_osc) begin
        if (!rst_n) begin
            pin_run <= '0;
            key_run <= '0;
        end else begin
            pin_run <= !pin_rst ? '0 : (pin_run == PIN_DUE ? pin_run : pin_run + 1'b1);
            key_run <= ((key_in & MASK) != MASK || MASK == 4'b0000) ? '0 :
                       (key_run == KEY_DUE ? key_run : key_run + 1'b1);
        end
    end

    assert_hold_until_osc_R1: assert property (@(posedge clk_osc)
        $rose(rst_n) |-> sys_rst);

    assert_pin_long_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (pin_run == PIN_DUE) |-> sys_rst);

    assert_key_long_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (key_run == KEY_DUE) |-> sys_rst);

    assert_release_strobe_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $fell(sys_rst) |-> core_start);

    assert_start_after_rst_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        core_start |-> (!sys_rst && $past(sys_rst)));

    assert_start_single_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        core_start |=> !core_start);

    assert_load_values_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        sys_rst |-> (init_pc_step == 8'h00 && init_pc_page == 4'h1 &&
                     init_np_page == 4'h1 && clr_iflag && clr_dflag));

    assert_idle_values_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !sys_rst |-> (init_pc_step == 8'h00 && init_pc_page == 4'h0 &&
                      init_np_page == 4'h0 && !clr_iflag && !clr_dflag));
endmodule

bind initial_reset_ctrl initial_reset_ctrl_sva #(
    .PIN_LEN (PIN_LEN),
    .KEY_LEN (KEY_LEN),
    .KEY_SEL (KEY_SEL)
) u_sva (
    .clk_osc      (clk_osc),
    .rst_n        (rst_n),
    .pin_rst      (pin_rst),
    .key_in       (key_in),
    .sys_rst      (sys_rst),
    .core_start   (core_start),
    .init_pc_step (init_pc_step),
    .init_pc_page (init_pc_page),
    .init_np_page (init_np_page),
    .clr_iflag    (clr_iflag),
    .clr_dflag    (clr_dflag)
);

// File: tb/tb_initial_reset_ctrl.sv
// Directed bench. One task per scenario; each task checks its own results.
module tb_initial_reset_ctrl;
    localparam int PIN_LEN = 10;
    localparam int KEY_LEN = 30;
    localparam int TMO     = 6;

    logic       clk_osc = 1'b0;
    logic       clk_ref = 1'b0;
    logic       osc_run = 1'b1;
    logic       rst_n   = 1'b0;
    logic       pin_rst = 1'b0;
    logic [3:0] key_in  = 4'b0000;

    logic       rst_a, rst_b, rst_c;
    logic       start_a, start_b, start_c;
    logic [7:0] step_a, step_b, step_c;
    logic [3:0] page_a, page_b, page_c, npp_a, npp_b, npp_c;
    logic       ifl_a, ifl_b, ifl_c, dfl_a, dfl_b, dfl_c;

    int errors = 0;
    int checks = 0;

    // 125 MHz oscillator clock that the bench can stop.
    always begin
        #4;
        if (osc_run) clk_osc = ~clk_osc;
    end

    // Independent 25 MHz reference clock.
    always #20 clk_ref = ~clk_ref;

    initial_reset_ctrl #(.PIN_LEN(PIN_LEN), .KEY_LEN(KEY_LEN), .OSC_TIMEOUT(TMO),
                         .KEY_SEL(rst_pkg::KEYSEL_THREE)) dut (
        .clk_osc(clk_osc), .clk_ref(clk_ref), .rst_n(rst_n), .pin_rst(pin_rst),
        .key_in(key_in), .sys_rst(rst_a), .core_start(start_a),
        .init_pc_step(step_a), .init_pc_page(page_a), .init_np_page(npp_a),
        .clr_iflag(ifl_a), .clr_dflag(dfl_a));

    initial_reset_ctrl #(.PIN_LEN(PIN_LEN), .KEY_LEN(KEY_LEN), .OSC_TIMEOUT(TMO),
                         .KEY_SEL(rst_pkg::KEYSEL_FOUR)) dut_all (
        .clk_osc(clk_osc), .clk_ref(clk_ref), .rst_n(rst_n), .pin_rst(pin_rst),
        .key_in(key_in), .sys_rst(rst_b), .core_start(start_b),
        .init_pc_step(step_b), .init_pc_page(page_b), .init_np_page(npp_b),
        .clr_iflag(ifl_b), .clr_dflag(dfl_b));

    initial_reset_ctrl #(.PIN_LEN(PIN_LEN), .KEY_LEN(KEY_LEN), .OSC_TIMEOUT(TMO),
                         .KEY_SEL(rst_pkg::KEYSEL_OFF)) dut_off (
        .clk_osc(clk_osc), .clk_ref(clk_ref), .rst_n(rst_n), .pin_rst(pin_rst),
        .key_in(key_in), .sys_rst(rst_c), .core_start(start_c),
        .init_pc_step(step_c), .init_pc_page(page_c), .init_np_page(npp_c),
        .clr_iflag(ifl_c), .clr_dflag(dfl_c));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance n oscillator edges and settle just after the last one.
    task automatic step(input int n);
        repeat (n) @(posedge clk_osc);
        #1;
    endtask

    task automatic wait_release();
        for (int i = 0; i < 200 && rst_a; i++) step(1);
    endtask

    task automatic t_power_on();
        #300;
        chk("R1 reset during rst_n low", rst_a, 1);
        chk("R9 step value in reset", step_a, 8'h00);
        chk("R9 page value in reset", page_a, 1);
        chk("R9 npp value in reset", npp_a, 1);
        chk("R9 flag clears in reset", {ifl_a, dfl_a}, 3);
        @(negedge clk_osc);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset held until osc confirmed", rst_a, 1);
        wait_release();
        chk("R1 reset released after round trip", rst_a, 0);
        chk("R9 page zero when idle", {page_a, npp_a, ifl_a, dfl_a}, 0);
        step(5);
    endtask

    task automatic t_pin_reject();
        pin_rst = 1'b1;
        step(PIN_LEN - 1);
        pin_rst = 1'b0;
        step(6);
        chk("R2 short pin pulse ignored", rst_a, 0);
    endtask

    task automatic t_pin_accept();
        pin_rst = 1'b1;
        step(PIN_LEN + 1);
        chk("R2 no reset one edge early", rst_a, 0);
        step(1);
        chk("R2 pin reset on due edge", rst_a, 1);
        chk("R9 page value on pin reset", page_a, 1);
        step(3);
        pin_rst = 1'b0;
        step(3);
        chk("R7 still in reset third edge", rst_a, 1);
        step(1);
        chk("R7 released fourth edge", rst_a, 0);
        chk("R8 start strobe on release", start_a, 1);
        step(1);
        chk("R8 start strobe single cycle", start_a, 0);
        step(3);
    endtask

    task automatic t_key_break();
        key_in = 4'b0111;
        step(KEY_LEN - 1);
        key_in = 4'b0101;
        step(1);
        key_in = 4'b0111;
        step(KEY_LEN - 1);
        key_in = 4'b0000;
        step(4);
        chk("R4 broken chord restarts count", rst_a, 0);
        key_in = 4'b0011;
        step(KEY_LEN + 8);
        chk("R3 two lines not enough for option 2", rst_a, 0);
        key_in = 4'b0000;
        step(4);
    endtask

    task automatic t_key_accept();
        key_in = 4'b0111;
        step(KEY_LEN + 1);
        chk("R4 no chord reset one edge early", rst_a, 0);
        step(1);
        chk("R4 chord reset on due edge", rst_a, 1);
        chk("R3 line 3 unselected for option 2", rst_a, 1);
        chk("R3 option 3 needs line 3", rst_b, 0);
        key_in = 4'b1111;
        step(KEY_LEN + 2);
        chk("R3 option 3 with all four lines", rst_b, 1);
        chk("R5 option 0 ignores full chord", rst_c, 0);
        key_in = 4'b1101;
        step(4);
        chk("R7 chord release", rst_a, 0);
        chk("R7 chord release option 3", rst_b, 0);
        key_in = 4'b0000;
        step(4);
    endtask

    task automatic t_osc_stop();
        osc_run = 1'b0;
        #((TMO + 6) * 40);
        chk("R6 reset with stopped oscillator", rst_a, 1);
        chk("R6 reset all instances", rst_c, 1);
        osc_run = 1'b1;
        step(60);
        chk("R6 release after restart", rst_a, 0);
        chk("R6 release after restart off-option", rst_c, 0);
    endtask

    initial begin
        t_power_on();
        t_pin_reject();
        t_pin_accept();
        t_key_break();
        t_key_accept();
        t_osc_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule